// File: doc/BRIEF.md
# Serial EEPROM Slave with Write Polling and Write Protect

This block is a synthesizable model of a two-wire serial EEPROM slave that holds a 2048-byte array. The block oversamples the open-drain clock and data lines with the system clock and finds start and stop conditions. It decodes a device byte in which a fixed 4-bit code sits in the upper bits, three block-select bits sit below it, and the read/write flag is the last bit. The three block bits and a following word-address byte form an 11-bit array address. A single-byte write is stored when the host issues a stop. That stop also starts a timed internal write cycle. While the cycle runs, the slave does not acknowledge its device byte, so a host can poll until the cycle ends.

Reads use one address counter, and every access advances it. Three read forms are supported. A current-address read needs only a device byte with the read flag. A random read sends a dummy write of the address, then a repeated start and a read. A sequential read continues for as long as the host acknowledges each byte. A write-protect input makes the whole array read-only: the addresses are still accepted, the data byte is refused, and nothing is stored.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A device byte whose bits 7:4 equal 1010 is acknowledged while no internal write is running. Any other value in bits 7:4 is not acknowledged.
- R2: A stop that ends an accepted data byte starts an internal write lasting WRITE_CYCLES clocks (default 1000). During that time every device byte is refused, and afterwards the device byte is acknowledged again. Polling therefore takes at least WRITE_CYCLES clocks from the stop to the first acknowledge.
- R3: When wpIn is high, the device byte and the word address are acknowledged, the data byte is not acknowledged, the array is unchanged, and no internal write is started (the next poll is acknowledged at once).
- R4: A byte write stores the data at the address {device byte bits 3:1, word address byte}. Bits 3:1 are the upper three address bits.
- R5: A random read (a write of the device byte and the word address, then a repeated start and a device byte with bit 0 = 1) returns the byte stored at that address.
- R6: A current-address read returns the byte at the address one above the last byte that was accessed.
- R7: In a sequential read, each host acknowledge advances the address by one and the next byte is sent. Address 2047 is followed by address 0.
- R8: Data is sent most significant bit first. The slave only pulls SDA low, and it changes its SDA drive only while SCL is low. SDA is released after reset.
- R9: After the host answers a read byte with no acknowledge, the slave releases SDA and stops sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled level of the serial clock line |
| sdaIn | input | 1 | Sampled level of the serial data line |
| wpIn | input | 1 | Write protect; high makes the array read-only |
| sdaLowEn | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The hardest condition to reach from the ports is a device byte arriving at the exact moment the internal write cycle ends. Whether it is acknowledged depends on the clock cycle in which its eighth bit completes. The bench gets close to this by polling again and again straight after each committed write. It times every poll and requires that the first accepted poll comes at least WRITE_CYCLES clocks after the stop, and no more than one poll length later. A second case that is hard to reach is the wrap of the address counter from 2047 to 0 in the middle of a sequential read. The bench sets this up by writing both end addresses and then reading across the boundary.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Which byte of a transfer the receiver is currently collecting
  typedef enum logic [1:0] {
    BYTE_DEV,
    BYTE_WADDR,
    BYTE_WDATA,
    BYTE_EXTRA
  } byteKind_t;

  // Strobes from the protocol control to the datapath, at most one per cycle
  typedef struct packed {
    logic shiftIn;    // take one received bit
    logic latchDev;   // keep block-select bits of the device byte
    logic setAddr;    // load counter from block bits and word address
    logic latchData;  // hold the received data byte for the write
    logic loadTx;     // fetch the byte at the counter, advance counter
    logic shiftTx;    // move to the next transmit bit
    logic commit;     // program the held byte and start the busy timer
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLevel;
      sdaPrev <= sdaLevel;
    end
  end

  assign sclLevel = sclSync[SYNC_STAGES-1];
  assign sdaLevel = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclLevel & ~sclPrev;
  assign sclFall  = ~sclLevel & sclPrev;
  assign startEv  = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopEv   = sclLevel & sclPrev & ~sdaPrev & sdaLevel;

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLevel,
  input  logic       wpIn,
  input  dpStrobe_t  stb,
  output logic [3:0] devCode,
  output logic       rwBit,
  output logic       txBit,
  output logic       busy
);

  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int BLOCK_W   = ADDR_W - 8;
  localparam int CNT_W     = $clog2(WRITE_CYCLES + 1);

  logic [7:0]         mem [MEM_DEPTH];
  logic [7:0]         rxShift, txShift, dataReg;
  logic [BLOCK_W-1:0] blockReg;
  logic [ADDR_W-1:0]  addrCnt;
  logic [CNT_W-1:0]   busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '1;
      dataReg  <= '0;
      blockReg <= '0;
      addrCnt  <= '0;
      busyCnt  <= '0;
    end else begin
      if (stb.shiftIn)   rxShift  <= {rxShift[6:0], sdaLevel};
      if (stb.latchDev)  blockReg <= rxShift[BLOCK_W:1];
      if (stb.latchData) dataReg  <= rxShift;
      if (stb.shiftTx)   txShift  <= {txShift[6:0], 1'b1};
      if (stb.setAddr) begin
        addrCnt <= {blockReg, rxShift};
      end else if (stb.loadTx) begin
        txShift <= mem[addrCnt];
        addrCnt <= addrCnt + 1'b1;
      end else if (stb.commit) begin
        addrCnt <= addrCnt + 1'b1;
      end
      if (stb.commit)          busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
    end
  end

  // Array storage, no reset
  always_ff @(posedge clk) begin
    if (stb.commit) mem[addrCnt] <= dataReg;
  end

  assign devCode = rxShift[7:4];
  assign rwBit   = rxShift[0];
  assign txBit   = txShift[7];
  assign busy    = (busyCnt != '0);

  // R2: the busy window opens only on a committed write
  p_busy_from_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.commit));

  // R2: a commit never lands inside a running write cycle
  p_no_commit_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !busy);

  // R3: protected array is never programmed
  p_no_commit_wp_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !wpIn);

  // R7: each fetched byte moves the counter by one, wrapping at the top
  p_counter_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && addrCnt == '1) |=> (addrCnt == '0));

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLevel,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       wpIn,
  input  logic [3:0] devCode,
  input  logic       rwBit,
  input  logic       txBit,
  input  logic       busy,
  output dpStrobe_t  stb,
  output logic       sdaLowEn
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} state_t;

  state_t    state, stateNext;
  byteKind_t kind, kindNext;
  logic [3:0] bitCnt, bitCntNext;
  logic ackOk, ackOkNext, isRead, isReadNext;
  logic pending, pendingNext, masterAck, masterAckNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= BYTE_DEV;
      bitCnt    <= '0;
      ackOk     <= 1'b0;
      isRead    <= 1'b0;
      pending   <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNext;
      kind      <= kindNext;
      bitCnt    <= bitCntNext;
      ackOk     <= ackOkNext;
      isRead    <= isReadNext;
      pending   <= pendingNext;
      masterAck <= masterAckNext;
    end
  end

  always_comb begin
    stateNext     = state;
    kindNext      = kind;
    bitCntNext    = bitCnt;
    ackOkNext     = ackOk;
    isReadNext    = isRead;
    pendingNext   = pending;
    masterAckNext = masterAck;
    stb           = '0;
    if (startEv) begin
      stateNext   = S_RX;
      kindNext    = BYTE_DEV;
      bitCntNext  = '0;
      pendingNext = 1'b0;
    end else if (stopEv) begin
      stateNext   = S_IDLE;
      stb.commit  = pending && !wpIn;
      pendingNext = 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitCntNext  = 4'(bitCnt + 1'b1);
          end else if (sclFall && bitCnt == 4'd8) begin
            stateNext = S_ACK;
            unique case (kind)
              BYTE_DEV: begin
                ackOkNext    = (devCode == DEV_CODE) && !busy;
                isReadNext   = rwBit;
                stb.latchDev = 1'b1;
              end
              BYTE_WADDR: begin
                ackOkNext   = 1'b1;
                stb.setAddr = 1'b1;
              end
              BYTE_WDATA: begin
                ackOkNext     = !wpIn;
                stb.latchData = !wpIn;
                pendingNext   = !wpIn;
              end
              default: ackOkNext = 1'b0;
            endcase
          end
        end
        S_ACK: begin
          if (sclFall) begin
            bitCntNext = '0;
            if (!ackOk) begin
              stateNext = S_IDLE;
            end else begin
              unique case (kind)
                BYTE_DEV: begin
                  if (isRead) begin
                    stateNext  = S_TX;
                    stb.loadTx = 1'b1;
                  end else begin
                    stateNext = S_RX;
                    kindNext  = BYTE_WADDR;
                  end
                end
                BYTE_WADDR: begin
                  stateNext = S_RX;
                  kindNext  = BYTE_WDATA;
                end
                default: begin
                  stateNext = S_RX;
                  kindNext  = BYTE_EXTRA;
                end
              endcase
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateNext = S_RACK;
            end else begin
              stb.shiftTx = 1'b1;
              bitCntNext  = 4'(bitCnt + 1'b1);
            end
          end
        end
        S_RACK: begin
          if (sclRise) masterAckNext = !sdaLevel;
          if (sclFall) begin
            bitCntNext = '0;
            if (masterAck) begin
              stateNext  = S_TX;
              stb.loadTx = 1'b1;
            end else begin
              stateNext = S_IDLE;
            end
          end
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  assign sdaLowEn = (state == S_ACK && ackOk) || (state == S_TX && !txBit);

  // R8: the slave moves SDA only during the low phase of SCL
  p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLowEn) |-> !sclLevel);

  // R4: one datapath action per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R9: after a host no-acknowledge the slave is silent
  p_silent_after_nack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK && sclFall && !masterAck) |=> !sdaLowEn);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W       = 11,
  parameter int         WRITE_CYCLES = 1000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_CODE     = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaLowEn
);

  logic sclLevel, sdaLevel, sclRise, sclFall, startEv, stopEv;
  logic [3:0] devCode;
  logic rwBit, txBit, busy;
  dpStrobe_t stb;

  eeprom_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv)
  );

  eeprom_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .wpIn(wpIn), .devCode(devCode), .rwBit(rwBit), .txBit(txBit),
    .busy(busy), .stb(stb), .sdaLowEn(sdaLowEn)
  );

  eeprom_datapath #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLevel(sdaLevel), .wpIn(wpIn), .stb(stb),
    .devCode(devCode), .rwBit(rwBit), .txBit(txBit), .busy(busy)
  );

endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;

  localparam int W = 1000;   // internal write length in clocks
  localparam int Q = 8;      // quarter bit period in clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic wp = 1'b0;
  logic sdaLowEn;
  logic sdaLine;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  int   lastAckCyc = 0;
  int   r8Bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdaLine = !(mSdaLow || sdaLowEn);

  serial_eeprom_slave #(.WRITE_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .wpIn(wp), .sdaLowEn(sdaLowEn)
  );

  // R8 monitor: slave drive may only change while SCL is low
  logic prevLow = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaLowEn != prevLow && mScl) r8Bad++;
    prevLow <= sdaLowEn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; waitQ();
    mScl = 1'b1;    waitQ();
    mSdaLow = 1'b1; waitQ();
    mScl = 1'b0;    waitQ();
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; waitQ();
    mScl = 1'b1;    waitQ();
    mSdaLow = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
    mSdaLow = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    acked = !sdaLine;
    lastAckCyc = cyc;
    waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ();
      mScl = 1'b0; waitQ();
    end
    mSdaLow = giveAck; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSdaLow = 1'b0;
  endtask

  function automatic logic [7:0] devByte(input logic [10:0] a, input bit rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic writeMem(input logic [10:0] a, input logic [7:0] d,
                          output bit k0, output bit k1, output bit k2, output int stopCyc);
    busStart();
    sendByte(devByte(a, 1'b0), k0);
    sendByte(a[7:0], k1);
    sendByte(d, k2);
    busStop();
    stopCyc = cyc;
  endtask

  task automatic poll(output int refused, output int ackCyc);
    bit k;
    refused = 0;
    ackCyc = 0;
    for (int n = 0; n < 40; n++) begin
      busStart();
      sendByte(8'hA0, k);
      busStop();
      if (k) begin
        ackCyc = lastAckCyc;
        break;
      end
      refused++;
    end
  endtask

  task automatic setAddress(input logic [10:0] a);
    bit k0, k1;
    busStart();
    sendByte(devByte(a, 1'b0), k0);
    sendByte(a[7:0], k1);
  endtask

  task automatic randomRead(input logic [10:0] a, output logic [7:0] d);
    bit k;
    setAddress(a);
    busStart();
    sendByte(devByte(a, 1'b1), k);
    recvByte(1'b0, d);
    busStop();
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [10:0] sweepAddr(input int i);
    return 11'(((i % 8) << 8) | ((i / 8) == 0 ? (i * 29 + 3) : (254 - i)));
  endfunction

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit k0, k1, k2, k;
    int stopCyc, refused, ackCyc;
    logic [7:0] d, d2;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(sdaLowEn == 1'b0, "R8 reset release", int'(sdaLowEn), 0);

    // R1: every value of the upper device code
    for (int c = 0; c < 16; c++) begin
      busStart();
      sendByte({4'(c), 4'b0000}, k);
      busStop();
      check(k == (c == 10), "R1 device code", int'(k), int'(c == 10));
    end

    // R4 / R2: write and timed polling
    writeMem(11'h3A5, 8'h5C, k0, k1, k2, stopCyc);
    check(k0 && k1 && k2, "R4 write acks", {k0, k1, k2}, 7);
    poll(refused, ackCyc);
    check(refused >= 1, "R2 polls refused", refused, 1);
    check(ackCyc - stopCyc >= W, "R2 busy length min", ackCyc - stopCyc, W);
    check(ackCyc - stopCyc <= W + 50 * Q, "R2 busy length max", ackCyc - stopCyc, W + 50 * Q);

    writeMem(11'h3A6, 8'hC3, k0, k1, k2, stopCyc);
    poll(refused, ackCyc);

    // R5 random read, R6 current-address read, R9 release after nack
    randomRead(11'h3A5, d);
    check(d == 8'h5C, "R5 random read", d, 8'h5C);
    busStart();
    sendByte(8'hA1, k);
    recvByte(1'b0, d);
    waitQ();
    check(sdaLowEn == 1'b0 && sdaLine == 1'b1, "R9 released after nack", int'(sdaLowEn), 0);
    busStop();
    check(d == 8'hC3, "R6 current address read", d, 8'hC3);

    // R7: sequential read across the top address
    writeMem(11'h7FF, 8'hE1, k0, k1, k2, stopCyc);
    poll(refused, ackCyc);
    writeMem(11'h000, 8'h1E, k0, k1, k2, stopCyc);
    poll(refused, ackCyc);
    setAddress(11'h7FF);
    busStart();
    sendByte(8'hAF, k);
    recvByte(1'b1, d);
    recvByte(1'b0, d2);
    busStop();
    check(d == 8'hE1, "R7 first byte at top", d, 8'hE1);
    check(d2 == 8'h1E, "R7 wrapped byte", d2, 8'h1E);

    // R3: write protect
    wp = 1'b1;
    writeMem(11'h3A5, 8'hFF, k0, k1, k2, stopCyc);
    check(k0 && k1, "R3 addresses accepted", {k0, k1}, 3);
    check(!k2, "R3 data refused", int'(k2), 0);
    poll(refused, ackCyc);
    check(refused == 0, "R3 no write cycle", refused, 0);
    wp = 1'b0;
    randomRead(11'h3A5, d);
    check(d == 8'h5C, "R3 array unchanged", d, 8'h5C);

    // R4 / R8: sweep across all blocks
    for (int i = 0; i < 16; i++) begin
      writeMem(sweepAddr(i), pattern(i), k0, k1, k2, stopCyc);
      poll(refused, ackCyc);
    end
    for (int i = 0; i < 16; i++) begin
      randomRead(sweepAddr(i), d);
      check(d == pattern(i), "R4 sweep readback", d, pattern(i));
    end

    check(r8Bad == 0, "R8 drive changes while SCL high", r8Bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule